// File: doc/BRIEF.md
# Serial Host Command Decoder

This block receives commands from an external host over a three-wire serial link. The link has a serial clock that the host may stop between words, a data line into the block, and a data line back to the host. Each command opens with a 16-bit address word. Bit 15 of that word picks the direction, and the lower 15 bits select a location. A write command then sends a 16-bit data word. A read command sends no data word; the block returns a 16-bit response instead. The serial inputs are brought into the system clock domain through a synchronizer, and edges of the serial clock are detected there.

Once a command is complete, the block sends it to one of three internal targets. A window of sixteen addresses for the time-slot table and a window of 256 addresses for the octal line-device bridge each receive a one-cycle strobe. Every other address goes to the signal-processor register space. That path uses a request that stays high until the engine acknowledges it, which happens once per time segment. While that request is pending, any further command is discarded, so the host has to leave a gap in the serial clock between an address and its data.

The receiver keeps the last 32 bits it received. A write of 0xFFFF to address 0x7FFF throws away any partly assembled word and returns the receiver to the address phase, even if the host has fallen out of word alignment.

Top module: `host_cmd_decoder`

## Requirements
- R1: Serial input bits are sampled on rising edges of the synchronized serial clock and assembled most significant bit first. The word presented on `cmd_addr_o` and `cmd_data_o` equals the word the host sent.
- R2: A command whose 15-bit address lies in 0x1400..0x140F produces exactly one single-cycle pulse on `tsa_stb_o`. Address 0x1410 does not produce this pulse.
- R3: A command whose 15-bit address lies in 0x1500..0x15FF produces exactly one single-cycle pulse on `oct_stb_o`. Addresses 0x14FF and 0x1600 do not produce this pulse.
- R4: Any other address raises `eng_req_o`. The request stays high, with `cmd_addr_o`, `cmd_data_o` and `cmd_rd_o` unchanged, until a cycle in which `eng_ack_i` is high. The request is low in the following cycle.
- R5: An address word with bit 15 = 1 is a read. It is dispatched as soon as the address word is complete, with `cmd_rd_o` = 1, and no data word is taken.
- R6: After a read is dispatched, a cycle with `rsp_vld_i` high loads `rsp_data_i`. Its MSB appears on `sdo_o`, and each falling serial clock edge after a rising one moves the next bit out. The host reads all 16 bits, MSB first, on the 16 rising edges that follow. `sdi_i` is ignored during those 16 edges.
- R7: An address word with bit 15 = 0 is a write. It is dispatched only after the following 16-bit data word, with `cmd_rd_o` = 0 and the data on `cmd_data_o`.
- R8: When the last 32 received bits equal 0x7FFF followed by 0xFFFF, nothing is dispatched for them and the receiver restarts at the address phase. This realigns a host that sent stray bits.
- R9: A command that completes while `eng_req_o` is high is discarded: no strobe fires and the held command fields are kept.
- R10: After reset, `sdo_o`, `tsa_stb_o`, `oct_stb_o`, `eng_req_o` and `cmd_rd_o` are 0.
- R11: At most one target is addressed at a time. Neither strobe fires while `eng_req_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck_i | input | 1 | Gapped serial clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| tsa_stb_o | output | 1 | One-cycle strobe to the time-slot table |
| oct_stb_o | output | 1 | One-cycle strobe to the octal-device bridge |
| eng_req_o | output | 1 | Engine register request, held until acknowledged |
| eng_ack_i | input | 1 | Engine acknowledge |
| cmd_rd_o | output | 1 | Dispatched command is a read |
| cmd_addr_o | output | 15 | Dispatched 15-bit address |
| cmd_data_o | output | 16 | Dispatched write data |
| rsp_vld_i | input | 1 | Read response valid from the addressed target |
| rsp_data_i | input | 16 | Read response word |

## Verification
The tests cover boundary addresses on both sides of each window: the first and last address inside each window, and the first address just outside it. This shows whether the decode compares the right number of address bits. Reads go to each of the three targets while the host drives ones on the data input, which separates correct response timing from a response that is shifted too early and from a receiver that keeps listening during the response. Flush is tried in two forms. The aligned form shows that the reserved pair is swallowed and not sent on. The form preceded by five stray bits shows that the match uses a sliding window: the stray bits produce one expected engine write, and the next command is then aligned again. A held acknowledge with a second command on top shows that the pending engine command is kept and the second one is discarded.

// File: rtl/hcd_pkg.sv
// Shared types for the serial host command decoder.
package hcd_pkg;
    // Receiver phase: collecting the address word, collecting the write data
    // word, or clocking out a read response.
    typedef enum logic [1:0] {
        PH_ADDR = 2'd0,
        PH_DATA = 2'd1,
        PH_RESP = 2'd2
    } phase_e;
endpackage

// File: rtl/hcd_sync_edge.sv
// Synchronizer and edge detector for the serial inputs.
// Both inputs pass through STAGES flops. The serial clock then goes through one
// more flop so that its rising and falling edges can be seen. Assumes the host
// holds each serial clock level for at least two system clock cycles.
module hcd_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic sdi_o
);
    logic [STAGES-1:0] sck_ff;
    logic [STAGES-1:0] sdi_ff;
    logic              sck_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // One synchronizer stage for each input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sck_ff[g] <= 1'b0;
                sdi_ff[g] <= 1'b0;
            end else if (g == 0) begin
                sck_ff[g] <= sck_i;
                sdi_ff[g] <= sdi_i;
            end else begin
                sck_ff[g] <= sck_ff[(g == 0) ? 0 : g-1];
                sdi_ff[g] <= sdi_ff[(g == 0) ? 0 : g-1];
            end
        end
    end

    // Previous synchronized clock level, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_ff[STAGES-1];
    end

    assign rise_o = sck_ff[STAGES-1] & ~sck_q;
    assign fall_o = ~sck_ff[STAGES-1] & sck_q;
    assign sdi_o  = sdi_ff[STAGES-1];
endmodule

// File: rtl/hcd_rx.sv
// Word assembler and phase sequencer.
// Shifts bits in MSB first on each rising serial edge. It pulses cmd_vld_o
// when a read address word or a write data word completes. A 2*W-bit history
// of received bits detects the flush pair regardless of word alignment. During
// a read response it only counts edges and ignores the data input.
module hcd_rx
    import hcd_pkg::*;
#(
    parameter int           W          = 16,
    parameter logic [W-1:0] FLUSH_ADDR = 16'h7FFF,
    parameter logic [W-1:0] FLUSH_DATA = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rise_i,
    input  logic         sdi_i,
    output logic         cmd_vld_o,
    output logic         cmd_rd_o,
    output logic [W-1:0] cmd_addr_o,
    output logic [W-1:0] cmd_data_o,
    output logic         shift_ok_o
);
    localparam int             CW        = $clog2(W);
    localparam logic [CW-1:0]  LAST      = CW'(W-1);
    localparam logic [2*W-1:0] FLUSH_PAT = {FLUSH_ADDR, FLUSH_DATA};

    phase_e         phase_q;
    logic [CW-1:0]  cnt_q;
    logic [W-1:0]   sh_q, sh_n;
    logic [2*W-1:0] hist_q, hist_n;

    // Next word and history values if the current bit is taken.
    always_comb begin
        sh_n   = {sh_q[W-2:0], sdi_i};
        hist_n = {hist_q[2*W-2:0], sdi_i};
    end

    // Phase, bit count, assembly and dispatch pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_ADDR;
            cnt_q      <= '0;
            sh_q       <= '0;
            hist_q     <= '0;
            cmd_vld_o  <= 1'b0;
            cmd_rd_o   <= 1'b0;
            cmd_addr_o <= '0;
            cmd_data_o <= '0;
        end else begin
            cmd_vld_o <= 1'b0;
            if (rise_i) begin
                if (phase_q == PH_RESP) begin
                    if (cnt_q == LAST) begin
                        phase_q <= PH_ADDR;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end else if (hist_n == FLUSH_PAT) begin
                    phase_q <= PH_ADDR;
                    cnt_q   <= '0;
                    sh_q    <= '0;
                    hist_q  <= '0;
                end else begin
                    sh_q   <= sh_n;
                    hist_q <= hist_n;
                    if (cnt_q == LAST) begin
                        cnt_q <= '0;
                        if (phase_q == PH_ADDR) begin
                            cmd_addr_o <= sh_n;
                            if (sh_n[W-1]) begin
                                phase_q    <= PH_RESP;
                                cmd_vld_o  <= 1'b1;
                                cmd_rd_o   <= 1'b1;
                                cmd_data_o <= '0;
                            end else begin
                                phase_q <= PH_DATA;
                            end
                        end else begin
                            cmd_data_o <= sh_n;
                            cmd_vld_o  <= 1'b1;
                            cmd_rd_o   <= 1'b0;
                            phase_q    <= PH_ADDR;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            end
        end
    end

    assign shift_ok_o = (phase_q == PH_RESP) && (cnt_q != '0);
endmodule

// File: rtl/hcd_tx.sv
// Read response shifter.
// Loads a response word when the target reports it valid. Shifts one bit
// toward the MSB on each falling serial edge that the receiver allows. The
// output is the MSB. Assumes the response arrives before the host's first
// rising edge of the response phase.
module hcd_tx #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         fall_i,
    input  logic         shift_ok_i,
    output logic         sdo_o
);
    logic [W-1:0] sh_q;

    // Load or shift the response word.
    always_ff @(posedge clk) begin
        if (!rst_n)                   sh_q <= '0;
        else if (load_i)              sh_q <= data_i;
        else if (fall_i && shift_ok_i) sh_q <= {sh_q[W-2:0], 1'b0};
    end

    assign sdo_o = sh_q[W-1];
endmodule

// File: rtl/hcd_dispatch.sv
// Address decoder and target handshake.
// Sends each completed command to the time-slot window or the bridge window
// as a one-cycle strobe. Anything else goes to the engine as a request held
// until it is acknowledged. Commands that arrive while the engine request is
// pending are discarded.
module hcd_dispatch #(
    parameter int          W        = 16,
    parameter int unsigned TSA_BASE = 'h1400,
    parameter int          TSA_SPAN = 4,
    parameter int unsigned OCT_BASE = 'h1500,
    parameter int          OCT_SPAN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cmd_vld_i,
    input  logic         cmd_rd_i,
    input  logic [W-1:0] cmd_addr_i,
    input  logic [W-1:0] cmd_data_i,
    input  logic         eng_ack_i,
    output logic         tsa_stb_o,
    output logic         oct_stb_o,
    output logic         eng_req_o,
    output logic         cmd_rd_o,
    output logic [W-2:0] cmd_addr_o,
    output logic [W-1:0] cmd_data_o
);
    localparam logic [W-2:0] TSA_B = (W-1)'(TSA_BASE);
    localparam logic [W-2:0] OCT_B = (W-1)'(OCT_BASE);

    logic [W-2:0] a_fld;
    logic         hit_tsa, hit_oct;

    // Window match on the upper address bits.
    always_comb begin
        a_fld   = cmd_addr_i[W-2:0];
        hit_tsa = (a_fld[W-2:TSA_SPAN] == TSA_B[W-2:TSA_SPAN]);
        hit_oct = (a_fld[W-2:OCT_SPAN] == OCT_B[W-2:OCT_SPAN]);
    end

    // Latch the command, fire strobes and manage the engine request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tsa_stb_o  <= 1'b0;
            oct_stb_o  <= 1'b0;
            eng_req_o  <= 1'b0;
            cmd_rd_o   <= 1'b0;
            cmd_addr_o <= '0;
            cmd_data_o <= '0;
        end else begin
            tsa_stb_o <= 1'b0;
            oct_stb_o <= 1'b0;
            if (eng_req_o && eng_ack_i) eng_req_o <= 1'b0;
            if (cmd_vld_i && !eng_req_o) begin
                cmd_rd_o   <= cmd_rd_i;
                cmd_addr_o <= a_fld;
                cmd_data_o <= cmd_data_i;
                if (hit_tsa)      tsa_stb_o <= 1'b1;
                else if (hit_oct) oct_stb_o <= 1'b1;
                else              eng_req_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/host_cmd_decoder.sv
// Serial host command decoder top.
// Connects the synchronizer, receiver, response shifter and dispatcher.
// Assumes the host leaves a gap in the serial clock whenever the engine may
// be busy, and that read responses come back before the response phase starts.
module host_cmd_decoder #(
    parameter int          W        = 16,
    parameter int          STAGES   = 2,
    parameter int unsigned TSA_BASE = 'h1400,
    parameter int          TSA_SPAN = 4,
    parameter int unsigned OCT_BASE = 'h1500,
    parameter int          OCT_SPAN = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck_i,
    input  logic         sdi_i,
    output logic         sdo_o,
    output logic         tsa_stb_o,
    output logic         oct_stb_o,
    output logic         eng_req_o,
    input  logic         eng_ack_i,
    output logic         cmd_rd_o,
    output logic [W-2:0] cmd_addr_o,
    output logic [W-1:0] cmd_data_o,
    input  logic         rsp_vld_i,
    input  logic [W-1:0] rsp_data_i
);
    logic         rise, fall, sdi_s;
    logic         rx_vld, rx_rd, shift_ok;
    logic [W-1:0] rx_addr, rx_data;

    hcd_sync_edge #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sdi_i(sdi_i),
        .rise_o(rise), .fall_o(fall), .sdi_o(sdi_s)
    );

    hcd_rx #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .sdi_i(sdi_s),
        .cmd_vld_o(rx_vld), .cmd_rd_o(rx_rd), .cmd_addr_o(rx_addr),
        .cmd_data_o(rx_data), .shift_ok_o(shift_ok)
    );

    hcd_tx #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load_i(rsp_vld_i), .data_i(rsp_data_i),
        .fall_i(fall), .shift_ok_i(shift_ok), .sdo_o(sdo_o)
    );

    hcd_dispatch #(
        .W(W), .TSA_BASE(TSA_BASE), .TSA_SPAN(TSA_SPAN),
        .OCT_BASE(OCT_BASE), .OCT_SPAN(OCT_SPAN)
    ) u_disp (
        .clk(clk), .rst_n(rst_n), .cmd_vld_i(rx_vld), .cmd_rd_i(rx_rd),
        .cmd_addr_i(rx_addr), .cmd_data_i(rx_data), .eng_ack_i(eng_ack_i),
        .tsa_stb_o(tsa_stb_o), .oct_stb_o(oct_stb_o), .eng_req_o(eng_req_o),
        .cmd_rd_o(cmd_rd_o), .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
    );
endmodule

// File: rtl/hcd_checker.sv
// Protocol checker for the decoder's dispatch side, bound to the top.
module hcd_checker #(
    parameter int          W        = 16,
    parameter int unsigned OCT_BASE = 'h1500,
    parameter int          OCT_SPAN = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tsa_stb_o,
    input logic         oct_stb_o,
    input logic         eng_req_o,
    input logic         eng_ack_i,
    input logic         cmd_rd_o,
    input logic [W-2:0] cmd_addr_o,
    input logic [W-1:0] cmd_data_o
);
    localparam logic [W-2:0] OCT_B = (W-1)'(OCT_BASE);

    // R2
    tsa_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tsa_stb_o |=> !tsa_stb_o);

    // R3
    oct_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oct_stb_o |-> (cmd_addr_o[W-2:OCT_SPAN] == OCT_B[W-2:OCT_SPAN]));

    // R4
    eng_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && !eng_ack_i) |=> (eng_req_o && $stable(cmd_addr_o)
                                       && $stable(cmd_data_o) && $stable(cmd_rd_o)));

    // R4
    eng_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req_o && eng_ack_i) |=> !eng_req_o);

    // R11
    target_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tsa_stb_o, oct_stb_o, eng_req_o}));
endmodule

bind host_cmd_decoder hcd_checker #(.W(W), .OCT_BASE(OCT_BASE), .OCT_SPAN(OCT_SPAN)) u_hcd_chk (
    .clk(clk), .rst_n(rst_n), .tsa_stb_o(tsa_stb_o), .oct_stb_o(oct_stb_o),
    .eng_req_o(eng_req_o), .eng_ack_i(eng_ack_i), .cmd_rd_o(cmd_rd_o),
    .cmd_addr_o(cmd_addr_o), .cmd_data_o(cmd_data_o)
);

// File: tb/tb_host_cmd_decoder.sv
module tb_host_cmd_decoder;
    localparam int W       = 16;
    localparam int HALF    = 4;
    localparam int ENG_LAT = 6;

    typedef struct {
        int          tgt;
        bit          rd;
        logic [14:0] a;
        logic [15:0] d;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        sck = 1'b0, sdi = 1'b0;
    logic        sdo, tsa_stb, oct_stb, eng_req, cmd_rd;
    logic        eng_ack = 1'b0, rsp_vld = 1'b0;
    logic [14:0] cmd_addr;
    logic [15:0] cmd_data, rsp_data = '0;

    int   vecs = 0, errs = 0, eng_wait = 0;
    bit   hold_ack = 1'b0, done = 1'b0, eng_prev = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    host_cmd_decoder dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .sdi_i(sdi), .sdo_o(sdo),
        .tsa_stb_o(tsa_stb), .oct_stb_o(oct_stb), .eng_req_o(eng_req),
        .eng_ack_i(eng_ack), .cmd_rd_o(cmd_rd), .cmd_addr_o(cmd_addr),
        .cmd_data_o(cmd_data), .rsp_vld_i(rsp_vld), .rsp_data_i(rsp_data)
    );

    function automatic int tgt_of(logic [14:0] a);
        if (a[14:4] == 11'h140) return 0;
        if (a[14:8] == 7'h15)   return 1;
        return 2;
    endfunction

    function automatic logic [15:0] resp_of(logic [14:0] a);
        return {a[7:0], ~a[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference monitor: every clock, any dispatch must match the model queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (tsa_stb || oct_stb || (eng_req && !eng_prev)) begin
                automatic int tg = tsa_stb ? 0 : (oct_stb ? 1 : 2);
                automatic string rq = (tg == 0) ? "R2" : ((tg == 1) ? "R3" : "R4");
                if (q.size() == 0) begin
                    chk(1'b0, {rq, "/R9 unexpected dispatch"}, {17'd0, cmd_addr}, 32'd0);
                end else begin
                    automatic exp_t e = q.pop_front();
                    chk(tg == e.tgt, {rq, " target"}, tg, e.tgt);
                    chk(cmd_addr == e.a, "R1 address", cmd_addr, e.a);
                    chk(cmd_rd == e.rd, "R5/R7 direction", cmd_rd, e.rd);
                    if (!e.rd) chk(cmd_data == e.d, "R7 write data", cmd_data, e.d);
                end
            end
            eng_prev = eng_req;
        end
    end

    // Target and engine responder.
    always @(negedge clk) begin
        rsp_vld = 1'b0;
        eng_ack = 1'b0;
        if ((tsa_stb || oct_stb) && cmd_rd) begin
            rsp_vld  = 1'b1;
            rsp_data = resp_of(cmd_addr);
        end
        if (eng_req && !hold_ack) begin
            if (eng_wait == ENG_LAT) begin
                eng_ack  = 1'b1;
                eng_wait = 0;
                if (cmd_rd) begin
                    rsp_vld  = 1'b1;
                    rsp_data = resp_of(cmd_addr);
                end
            end else begin
                eng_wait++;
            end
        end
    end

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(input logic b);
        @(negedge clk);
        sdi = b;
        gap(HALF);
        sck = 1'b1;
        gap(HALF);
        sck = 1'b0;
    endtask

    task automatic sword(input logic [15:0] w);
        for (int i = 15; i >= 0; i--) sbit(w[i]);
    endtask

    task automatic rword(output logic [15:0] r);
        for (int i = 15; i >= 0; i--) begin
            sdi = 1'b1;
            gap(HALF);
            r[i] = sdo;
            sck = 1'b1;
            gap(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [15:0] d, input bit expect_it);
        if (expect_it) q.push_back('{tgt_of(a), 1'b0, a, d});
        sword({1'b0, a});
        gap(12);
        sword(d);
        gap(24);
        chk(q.size() == 0, "R7 write dispatched once", q.size(), 0);
    endtask

    task automatic rd(input logic [14:0] a);
        logic [15:0] r;
        q.push_back('{tgt_of(a), 1'b1, a, 16'h0});
        sword({1'b1, a});
        gap(30);
        chk(q.size() == 0, "R5 read dispatched after address only", q.size(), 0);
        rword(r);
        chk(r == resp_of(a), "R6 read response", r, resp_of(a));
        gap(10);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errs++;
            $display("FAIL watchdog expired (all requirements)");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        gap(5);
        rst_n = 1'b1;
        gap(2);
        // R10 reset state
        chk({sdo, tsa_stb, oct_stb, eng_req, cmd_rd} == 5'b0, "R10 reset outputs",
            {sdo, tsa_stb, oct_stb, eng_req, cmd_rd}, 0);

        // R2 window edges, R4 just above
        wr(15'h1400, 16'hA5A5, 1);
        wr(15'h140F, 16'h5A5A, 1);
        wr(15'h1410, 16'h0001, 1);
        // R3 window edges and neighbours
        wr(15'h1500, 16'h8000, 1);
        wr(15'h15FF, 16'hFFFE, 1);
        wr(15'h14FF, 16'h1234, 1);
        wr(15'h1600, 16'h4321, 1);
        // R1 bit patterns
        for (int k = 0; k < 4; k++) wr(15'h1404 + 15'(k), 16'h0001 << (k * 5), 1);

        // R5 R6 reads to each target, sdi driven high during response
        rd(15'h1403);
        rd(15'h15A5);
        rd(15'h0123);
        wr(15'h1405, 16'h00FF, 1);  // R6 receiver not disturbed by response clocks

        // R8 aligned flush: nothing dispatched, next command clean
        sword(16'h7FFF);
        gap(12);
        sword(16'hFFFF);
        gap(24);
        chk(q.size() == 0 && !eng_req, "R8 flush not dispatched", eng_req, 0);
        wr(15'h1401, 16'hC3C3, 1);

        // R8 misaligned flush: five stray zeros shift words by 5 bits
        q.push_back('{2, 1'b0, 15'h03FF, 16'hFFFF});
        for (int k = 0; k < 5; k++) sbit(1'b0);
        sword(16'h7FFF);
        sword(16'hFFFF);
        gap(24);
        chk(q.size() == 0, "R8 stray-bit engine write", q.size(), 0);
        wr(15'h1402, 16'h3C3C, 1);

        // R9 command dropped while engine busy; R4 held then released
        hold_ack = 1'b1;
        wr(15'h0200, 16'h1234, 1);
        wr(15'h1404, 16'h9999, 0);
        chk(eng_req == 1'b1, "R9 request still held", eng_req, 1);
        chk(cmd_addr == 15'h0200 && cmd_data == 16'h1234, "R9 held command kept",
            {cmd_addr, cmd_data}, {15'h0200, 16'h1234});
        hold_ack = 1'b0;
        gap(20);
        chk(eng_req == 1'b0, "R4 request released by ack", eng_req, 0);
        wr(15'h1406, 16'h7777, 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule